// File: doc/BRIEF.md
# Board Control Register File

This block is a small memory-mapped register set for the housekeeping logic of a development board. A processor reaches it over a plain 32-bit bus with a one-cycle write strobe and a combinational read path. It drives an eight-LED bar, an eight-character text display buffer, a break/reset byte, a general-purpose output byte and a set of bit-banged serial pins that talk to an external two-wire EEPROM.

The display can be loaded in two ways. Writing one 32-bit word renders the whole value as eight uppercase hexadecimal characters. Alternatively, software can place single characters one at a time through eight word-spaced slots. Writing one magic key word to a dedicated offset raises a one-cycle request to reset the system. The serial pins are driven from a stored output word. The data line coming back from the EEPROM appears in bit 0 of an input register. A select bit gates a loopback of the output word onto a general-purpose input offset. The display rendering and the serial-port window that shares the address range lie outside this block; that window is left unmapped.

Top module: `board_ctl_regs`

## Requirements
- R1: Only address bits 19:0 are decoded, so an access at `0xFFF00408` hits the same register as one at `0x408`.
- R2: Any offset not listed here reads as zero and ignores writes. The switch word (0x200) and jumper word (0x210) always read zero, and writes to them are ignored.
- R3: The status word at 0x208 reads 0x12 when parameter `BIG_ENDIAN` is 1 (the default) and 0x10 when it is 0.
- R4: The LED register at 0x408 keeps bits 7:0 of a write, reads back that byte, and drives `led_o`.
- R5: A write to 0x410 loads all eight display characters with the uppercase hex ASCII digits of the word. Character 0 (`disp_chars_o[7:0]`) takes bits 31:28, and character k takes bits 31-4k down to 28-4k.
- R6: A write to offset 0x418 + 8k (k = 0..7) stores the low data byte into character k, at `disp_chars_o[8k+7:8k]`. Offsets inside that range that are not multiples of 8 are ignored.
- R7: A write of exactly 0x00000042 to 0x500 makes `sys_rst_req_o` high for the one cycle after the write edge. Any other value gives no pulse.
- R8: The break register (0x508) and general output register (0xA00) keep 8 bits. The pin-enable register (0xB08) keeps 2 bits, and the loopback-select register (0xB18) keeps 1 bit. Each reads back its stored value and drives its output.
- R9: A write to 0xB10 stores the full 32-bit word, which reads back unchanged. Bit 1 of that word drives `scl_o` and bit 0 drives `sda_o`.
- R10: A read of 0xB00 returns the input value 0x3 with bit 0 replaced by `sda_i`. A read of 0xA08 returns the 0xB10 word when the select bit is 1, and zero when it is 0.
- R11: After reset: LEDs 0, break 0x0A, general output 0, pin enables 0, serial output word 3, select 1, all eight characters 0x20 (space), and no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 32 | Byte address; bits 19:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| led_o | output | 8 | LED bar |
| disp_chars_o | output | 64 | Display characters, character k in bits 8k+7:8k |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| brk_o | output | 8 | Break/reset register contents |
| gpout_o | output | 8 | General-purpose output |
| i2c_oe_o | output | 2 | Serial pin enables |
| scl_o | output | 1 | Serial clock toward the EEPROM |
| sda_o | output | 1 | Serial data toward the EEPROM |
| sda_i | input | 1 | Serial data returned by the EEPROM |

## Verification
The hex display load is tried with a word of mixed digits and letters (`0x0123ABCF`) and with a descending word (`0xFEDC9876`). Together they show whether the nibble order is reversed and whether the digit-to-letter boundary is placed correctly. Single-character writes hit the first slot, the last slot and a middle slot with a wide data word, which separates index arithmetic from byte truncation; a misaligned offset must leave the buffer untouched. The soft-reset key is compared against 0x43 and 0x142, which separates an exact full-word match from a partial match. The returned data line is driven both low and high so that bit 0 of the input word is shown to follow `sda_i`.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam logic [19:0] OFF_SWITCH  = 20'h00200;
  localparam logic [19:0] OFF_STATUS  = 20'h00208;
  localparam logic [19:0] OFF_JUMPER  = 20'h00210;
  localparam logic [19:0] OFF_LED     = 20'h00408;
  localparam logic [19:0] OFF_HEXWORD = 20'h00410;
  localparam logic [19:0] OFF_CHAR0   = 20'h00418;
  localparam logic [19:0] OFF_SOFTRST = 20'h00500;
  localparam logic [19:0] OFF_BREAK   = 20'h00508;
  localparam logic [19:0] OFF_GPOUT   = 20'h00a00;
  localparam logic [19:0] OFF_GPIN    = 20'h00a08;
  localparam logic [19:0] OFF_I2CIN   = 20'h00b00;
  localparam logic [19:0] OFF_I2COE   = 20'h00b08;
  localparam logic [19:0] OFF_I2COUT  = 20'h00b10;
  localparam logic [19:0] OFF_I2CSEL  = 20'h00b18;

  localparam logic [31:0] SOFTRST_KEY = 32'h0000_0042;
  localparam logic [7:0]  STATUS_BE   = 8'h12;
  localparam logic [7:0]  STATUS_LE   = 8'h10;
  localparam logic [7:0]  BLANK_CHAR  = 8'h20;
  localparam logic [7:0]  BREAK_RST   = 8'h0a;
  localparam logic [1:0]  I2CIN_CONST = 2'b11;

  typedef struct packed {
    logic led;
    logic hexword;
    logic softrst;
    logic brk;
    logic gpout;
    logic i2coe;
    logic i2cout;
    logic i2csel;
  } wr_hits_t;

  function automatic logic [7:0] hex_char(input logic [3:0] nib);
    if (nib < 4'd10) hex_char = 8'h30 + {4'h0, nib};
    else             hex_char = 8'h37 + {4'h0, nib};
  endfunction

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int DEC_W       = 20,
  parameter int NUM_CHARS   = 8,
  parameter int STRIDE_LG   = 3
) (
  input  logic                 we,
  input  logic [DEC_W-1:0]     off,
  output wr_hits_t             hits,
  output logic [NUM_CHARS-1:0] char_we
);

  always_comb begin
    hits         = '0;
    hits.led     = we && (off == DEC_W'(OFF_LED));
    hits.hexword = we && (off == DEC_W'(OFF_HEXWORD));
    hits.softrst = we && (off == DEC_W'(OFF_SOFTRST));
    hits.brk     = we && (off == DEC_W'(OFF_BREAK));
    hits.gpout   = we && (off == DEC_W'(OFF_GPOUT));
    hits.i2coe   = we && (off == DEC_W'(OFF_I2COE));
    hits.i2cout  = we && (off == DEC_W'(OFF_I2COUT));
    hits.i2csel  = we && (off == DEC_W'(OFF_I2CSEL));
  end

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_slot
    localparam logic [DEC_W-1:0] SLOT_OFF =
      DEC_W'(OFF_CHAR0) + DEC_W'(k << STRIDE_LG);
    assign char_we[k] = we && (off == SLOT_OFF);
  end

endmodule

// File: rtl/board_ctl_display.sv
module board_ctl_display
  import board_ctl_pkg::*;
#(
  parameter int NUM_CHARS = 8,
  parameter int DATA_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hex_load,
  input  logic [NUM_CHARS-1:0]   char_we,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NUM_CHARS*8-1:0] chars
);

  for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
    localparam int NIB_LO = 4 * (NUM_CHARS - 1 - k);
    logic [7:0] char_q;

    always_ff @(posedge clk) begin
      if (rst)             char_q <= BLANK_CHAR;
      else if (hex_load)   char_q <= hex_char(wdata[NIB_LO +: 4]);
      else if (char_we[k]) char_q <= wdata[7:0];
    end

    assign chars[8*k +: 8] = char_q;
  end

endmodule

// File: rtl/board_ctl_i2c.sv
module board_ctl_i2c
  import board_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_oe,
  input  logic              we_out,
  input  logic              we_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sda_i,
  output logic [1:0]        oe_q,
  output logic [DATA_W-1:0] out_q,
  output logic              sel_q,
  output logic [DATA_W-1:0] rd_inp,
  output logic [DATA_W-1:0] rd_gpin,
  output logic              scl_o,
  output logic              sda_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= '0;
      out_q <= DATA_W'(2'b11);
      sel_q <= 1'b1;
    end else begin
      if (we_oe)  oe_q  <= wdata[1:0];
      if (we_out) out_q <= wdata;
      if (we_sel) sel_q <= wdata[0];
    end
  end

  assign scl_o   = out_q[1];
  assign sda_o   = out_q[0];
  assign rd_inp  = {{(DATA_W-2){1'b0}}, I2CIN_CONST[1], sda_i};
  assign rd_gpin = sel_q ? out_q : '0;

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int DEC_W      = 20,
  parameter int NUM_CHARS  = 8,
  parameter int STRIDE_LG  = 3,
  parameter int LED_W      = 8,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic [LED_W-1:0]       led_o,
  output logic [NUM_CHARS*8-1:0] disp_chars_o,
  output logic                   sys_rst_req_o,
  output logic [7:0]             brk_o,
  output logic [7:0]             gpout_o,
  output logic [1:0]             i2c_oe_o,
  output logic                   scl_o,
  output logic                   sda_o,
  input  logic                   sda_i
);

  localparam logic [7:0] STATUS_VAL = BIG_ENDIAN ? STATUS_BE : STATUS_LE;

  logic [DEC_W-1:0]     off;
  wr_hits_t             hits;
  logic [NUM_CHARS-1:0] char_we;
  logic [DATA_W-1:0]    i2c_out_q;
  logic                 i2c_sel_q;
  logic [DATA_W-1:0]    rd_inp;
  logic [DATA_W-1:0]    rd_gpin;
  logic [LED_W-1:0]     led_q;
  logic [7:0]           brk_q;
  logic [7:0]           gpout_q;
  logic                 req_q;

  assign off = bus_addr[DEC_W-1:0];

  board_ctl_decode #(
    .DEC_W     (DEC_W),
    .NUM_CHARS (NUM_CHARS),
    .STRIDE_LG (STRIDE_LG)
  ) u_decode (
    .we      (bus_we),
    .off     (off),
    .hits    (hits),
    .char_we (char_we)
  );

  board_ctl_display #(
    .NUM_CHARS (NUM_CHARS),
    .DATA_W    (DATA_W)
  ) u_display (
    .clk      (clk),
    .rst      (rst),
    .hex_load (hits.hexword),
    .char_we  (char_we),
    .wdata    (bus_wdata),
    .chars    (disp_chars_o)
  );

  board_ctl_i2c #(
    .DATA_W (DATA_W)
  ) u_i2c (
    .clk     (clk),
    .rst     (rst),
    .we_oe   (hits.i2coe),
    .we_out  (hits.i2cout),
    .we_sel  (hits.i2csel),
    .wdata   (bus_wdata),
    .sda_i   (sda_i),
    .oe_q    (i2c_oe_o),
    .out_q   (i2c_out_q),
    .sel_q   (i2c_sel_q),
    .rd_inp  (rd_inp),
    .rd_gpin (rd_gpin),
    .scl_o   (scl_o),
    .sda_o   (sda_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      led_q   <= '0;
      brk_q   <= BREAK_RST;
      gpout_q <= '0;
      req_q   <= 1'b0;
    end else begin
      if (hits.led)   led_q   <= bus_wdata[LED_W-1:0];
      if (hits.brk)   brk_q   <= bus_wdata[7:0];
      if (hits.gpout) gpout_q <= bus_wdata[7:0];
      req_q <= hits.softrst && (bus_wdata == DATA_W'(SOFTRST_KEY));
    end
  end

  assign led_o         = led_q;
  assign brk_o         = brk_q;
  assign gpout_o       = gpout_q;
  assign sys_rst_req_o = req_q;

  always_comb begin
    bus_rdata = '0;
    case (off)
      DEC_W'(OFF_STATUS): bus_rdata = DATA_W'(STATUS_VAL);
      DEC_W'(OFF_LED):    bus_rdata = DATA_W'(led_q);
      DEC_W'(OFF_BREAK):  bus_rdata = DATA_W'(brk_q);
      DEC_W'(OFF_GPOUT):  bus_rdata = DATA_W'(gpout_q);
      DEC_W'(OFF_GPIN):   bus_rdata = rd_gpin;
      DEC_W'(OFF_I2CIN):  bus_rdata = rd_inp;
      DEC_W'(OFF_I2COE):  bus_rdata = DATA_W'(i2c_oe_o);
      DEC_W'(OFF_I2COUT): bus_rdata = i2c_out_q;
      DEC_W'(OFF_I2CSEL): bus_rdata = DATA_W'(i2c_sel_q);
      default:            bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/board_ctl_checker.sv
module board_ctl_checker #(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [7:0]  led_o,
  input logic [63:0] disp_chars_o,
  input logic        sys_rst_req_o,
  input logic        scl_o,
  input logic        sda_o,
  input logic        sda_i
);

  logic [19:0] off;
  logic        disp_wr;
  assign off     = bus_addr[19:0];
  assign disp_wr = bus_we && (off >= 20'h00410) && (off <= 20'h00450);

  // R7: a reset request only follows a key write in the previous cycle
  a_r7_req_cause: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req_o |-> $past(bus_we && off == 20'h00500 && bus_wdata == 32'h42));

  // R4: LEDs change only on their own write
  a_r4_led_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && off == 20'h00408) |=> $stable(led_o));

  // R9: serial pins change only on a write to the output word
  a_r9_pins_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && off == 20'h00b10) |=> $stable({scl_o, sda_o}));

  // R5 / R6: display changes only on a display write
  a_r6_disp_hold: assert property (@(posedge clk) disable iff (rst)
    !disp_wr |=> $stable(disp_chars_o));

  // R10: input word bit 0 follows the returned data line
  a_r10_inp_sda: assert property (@(posedge clk) disable iff (rst)
    (off == 20'h00b00) |-> (bus_rdata[0] == sda_i && bus_rdata[31:1] == 31'h1));

  // R3: status constant
  a_r3_status: assert property (@(posedge clk) disable iff (rst)
    (off == 20'h00208) |-> (bus_rdata == (BIG_ENDIAN ? 32'h12 : 32'h10)));

  // R2: switch and jumper words read zero
  a_r2_fixed_zero: assert property (@(posedge clk) disable iff (rst)
    (off == 20'h00200 || off == 20'h00210) |-> (bus_rdata == 32'h0));

endmodule

bind board_ctl_regs board_ctl_checker #(.BIG_ENDIAN(BIG_ENDIAN)) u_checker (
  .clk           (clk),
  .rst           (rst),
  .bus_we        (bus_we),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .led_o         (led_o),
  .disp_chars_o  (disp_chars_o),
  .sys_rst_req_o (sys_rst_req_o),
  .scl_o         (scl_o),
  .sda_o         (sda_o),
  .sda_i         (sda_i)
);

// File: tb/test_board_ctl_regs.sv
`timescale 1ns/1ps
module test_board_ctl_regs;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_o;
  logic [63:0] disp_chars_o;
  logic        sys_rst_req_o;
  logic [7:0]  brk_o;
  logic [7:0]  gpout_o;
  logic [1:0]  i2c_oe_o;
  logic        scl_o;
  logic        sda_o;
  logic        sda_i = 1'b1;

  int n_vec  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  board_ctl_regs i_board_ctl_regs (
    .clk           (clk),
    .rst           (rst),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .led_o         (led_o),
    .disp_chars_o  (disp_chars_o),
    .sys_rst_req_o (sys_rst_req_o),
    .brk_o         (brk_o),
    .gpout_o       (gpout_o),
    .i2c_oe_o      (i2c_oe_o),
    .scl_o         (scl_o),
    .sda_o         (sda_o),
    .sda_i         (sda_i)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 32'h0; bus_wdata = 32'h0;
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, {32'h0, bus_rdata}, {32'h0, exp});
  endtask

  function automatic logic [63:0] hex_text(input logic [31:0] v);
    string digits = "0123456789ABCDEF";
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = digits[v[31-4*k -: 4]];
    return r;
  endfunction

  task automatic t_reset;
    check("R11 led", {56'h0, led_o}, 64'h0);
    check("R11 chars", disp_chars_o, {8{8'h20}});
    check("R11 req", {63'h0, sys_rst_req_o}, 64'h0);
    check("R11 pins", {62'h0, scl_o, sda_o}, 64'h3);
    check("R11 oe", {62'h0, i2c_oe_o}, 64'h0);
    rd_chk("R11 break", 32'h508, 32'h0a);
    rd_chk("R11 gpout", 32'ha00, 32'h00);
    rd_chk("R11 i2cout", 32'hb10, 32'h3);
    rd_chk("R11 i2csel", 32'hb18, 32'h1);
  endtask

  task automatic t_decode;
    bus_wr(32'hfff0_0408, 32'h0000_0123);
    check("R1 alias led", {56'h0, led_o}, 64'h23);
    rd_chk("R1 R4 led read", 32'h0000_0408, 32'h23);
    rd_chk("R1 alias read", 32'h1230_0408, 32'h23);
  endtask

  task automatic t_unmapped;
    bus_wr(32'h404, 32'hffff_ffff);
    bus_wr(32'h900, 32'hffff_ffff);
    bus_wr(32'h200, 32'hffff_ffff);
    bus_wr(32'h210, 32'hffff_ffff);
    check("R2 led untouched", {56'h0, led_o}, 64'h23);
    check("R2 chars untouched", disp_chars_o, {8{8'h20}});
    rd_chk("R2 unmapped", 32'h404, 32'h0);
    rd_chk("R2 uart window", 32'h900, 32'h0);
    rd_chk("R2 switch", 32'h200, 32'h0);
    rd_chk("R2 jumper", 32'h210, 32'h0);
    rd_chk("R3 status", 32'h208, 32'h12);
  endtask

  task automatic t_display;
    bus_wr(32'h410, 32'h0123_abcf);
    check("R5 hex mixed", disp_chars_o, hex_text(32'h0123_abcf));
    bus_wr(32'h410, 32'hfedc_9876);
    check("R5 hex descending", disp_chars_o, hex_text(32'hfedc_9876));
    bus_wr(32'h418, 32'h0000_0061);
    bus_wr(32'h450, 32'h0000_007a);
    bus_wr(32'h438, 32'h0000_01ff);
    check("R6 slot0", {56'h0, disp_chars_o[7:0]}, 64'h61);
    check("R6 slot7", {56'h0, disp_chars_o[63:56]}, 64'h7a);
    check("R6 slot4 byte", {56'h0, disp_chars_o[39:32]}, 64'hff);
    check("R6 slot1 kept", {56'h0, disp_chars_o[15:8]}, 64'h45);
    bus_wr(32'h41c, 32'h0000_0055);
    check("R6 misaligned ignored", disp_chars_o,
          {8'h7a, 8'h37, 8'h38, 8'hff, 8'h43, 8'h44, 8'h45, 8'h61});
  endtask

  task automatic t_softreset;
    bus_wr(32'h500, 32'h42);
    check("R7 pulse high", {63'h0, sys_rst_req_o}, 64'h1);
    @(negedge clk);
    check("R7 pulse one cycle", {63'h0, sys_rst_req_o}, 64'h0);
    bus_wr(32'h500, 32'h43);
    check("R7 wrong key", {63'h0, sys_rst_req_o}, 64'h0);
    bus_wr(32'h500, 32'h142);
    check("R7 upper bits", {63'h0, sys_rst_req_o}, 64'h0);
  endtask

  task automatic t_widths;
    bus_wr(32'h508, 32'hffff);
    bus_wr(32'ha00, 32'h1a5);
    bus_wr(32'hb08, 32'hff);
    check("R8 brk out", {56'h0, brk_o}, 64'hff);
    check("R8 gpout out", {56'h0, gpout_o}, 64'ha5);
    check("R8 oe out", {62'h0, i2c_oe_o}, 64'h3);
    rd_chk("R8 brk read", 32'h508, 32'hff);
    rd_chk("R8 gpout read", 32'ha00, 32'ha5);
    rd_chk("R8 oe read", 32'hb08, 32'h3);
  endtask

  task automatic t_i2c;
    bus_wr(32'hb10, 32'hdead_bee2);
    check("R9 pins", {62'h0, scl_o, sda_o}, 64'h2);
    rd_chk("R9 word read", 32'hb10, 32'hdead_bee2);
    rd_chk("R10 loopback on", 32'ha08, 32'hdead_bee2);
    bus_wr(32'hb10, 32'h1);
    check("R9 pins swap", {62'h0, scl_o, sda_o}, 64'h1);
    bus_wr(32'hb18, 32'hfe);
    rd_chk("R8 sel read", 32'hb18, 32'h0);
    rd_chk("R10 loopback off", 32'ha08, 32'h0);
    sda_i = 1'b0;
    rd_chk("R10 inp low", 32'hb00, 32'h2);
    sda_i = 1'b1;
    rd_chk("R10 inp high", 32'hb00, 32'h3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_unmapped();
    t_display();
    t_softreset();
    t_widths();
    t_i2c();
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule